// File: doc/BRIEF.md
# Dual-Rail Early-Output Adder Stage with Carry Rendezvous

This block adds two dual-rail operands and a dual-rail carry-in under a four-phase return-to-zero protocol. Every bit is encoded on a true rail and a false rail. Both rails low is the spacer, and exactly one rail high is a valid value. The adder is a ripple chain of early-output cells. A cell may produce its outputs from only part of its inputs, and it may clear them after only part of its inputs have returned to spacer. The carry path in each cell uses AND-OR gates that do not wait for all of their inputs. The sum path of each cell goes through four two-input C-elements and two OR gates.

Because the cells do not confirm that every input has arrived, the stage restores indication in one place. The carry-out pair of the last cell does not go straight out. It passes through a rendezvous of two C-elements, one per rail. Each of these C-elements combines its rail with an active-high completion signal from the stage's completion detector. The sum pairs go straight to the next stage. The carry-out therefore turns valid only after completion has been signalled, and it returns to spacer only after completion has dropped again.

The design is modelled on a clock. Each C-element is a state bit that takes the value `x&y | (x|y)&z` at each rising edge. The AND-OR gates are combinational. Reset is synchronous and active high.

Top module: `eo_adder_stage`

## Requirements
- R1: After reset, every sum rail and both carry-out rails are low (spacer).
- R2: Valid operands and carry-in, once held through one rising edge, give sums where sum_t[i] equals bit i of A+B+Cin and sum_f[i] is its inverse.
- R3: While the completion input is low, the carry-out rails stay low, even though the sums and the internal carry are already valid.
- R4: One rising edge after completion goes high while the inputs are valid, the carry-out shows bit 32 of A+B+Cin: cout_t equals that bit and cout_f is its inverse.
- R5: While completion stays high, the carry-out holds its valid value after all inputs have returned to spacer.
- R6: One rising edge after completion goes low while the inputs are spacer, both carry-out rails are low.
- R7: One rising edge after every input rail is low, every sum rail is low.
- R8: Early reset. Take bit 0 generating a carry (A=1, B=1, Cin=0). Then clear every rail except b_t[0] and cin_f. One rising edge later, sum_t[1] and sum_f[1] are low while sum_f[0] stays high. sum_f[0] clears once cin_f is low too.
- R9: The two carry-out rails are never high together. No cell's carry rails are high together while its inputs are legal.
- R10: The two rails of any sum bit are never high together.
- R11: A carry that ripples through the full width (all-ones plus zero plus carry-in) gives sum zero and carry-out one with the same one-edge sum latency.
- R12: If completion goes high while the internal carry is spacer, the carry-out stays spacer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that updates the C-element state |
| rst | input | 1 | Synchronous active-high reset, clears all C-elements |
| a_t | input | 32 | Operand A, true rails |
| a_f | input | 32 | Operand A, false rails |
| b_t | input | 32 | Operand B, true rails |
| b_f | input | 32 | Operand B, false rails |
| cin_t | input | 1 | Carry-in, true rail |
| cin_f | input | 1 | Carry-in, false rail |
| ack | input | 1 | Stage completion, high when complete, low when fully reset |
| sum_t | output | 32 | Sum, true rails |
| sum_f | output | 32 | Sum, false rails |
| cout_t | output | 1 | Synchronized carry-out, true rail |
| cout_f | output | 1 | Synchronized carry-out, false rail |

## Verification
The hardest case to reach from the ports is the early reset itself. Here some sums have already cleared while one cell still holds its sum because its carry-in has not yet returned to spacer. The bench builds this state on purpose. It drives a partial spacer that keeps exactly one operand rail and the carry-in rail of bit 0. It then observes the neighbouring bit clear while bit 0 stays put.

The rendezvous behaviour is checked in both phases. The bench holds completion low after valid sums have appeared, and it holds completion high after the inputs have already returned to spacer. In this way each edge of the carry-out can only follow the completion signal.

// File: rtl/eo_adder_pkg.sv
package eo_adder_pkg;

    localparam int unsigned DEF_WIDTH = 32;

    // One dual-rail wire: t high means 1, f high means 0, both low is spacer
    typedef struct packed {
        logic t;
        logic f;
    } rail_t;

    localparam rail_t RAIL_SPACER = '{t: 1'b0, f: 1'b0};

    // Input-incomplete two-term AND-OR gate
    function automatic logic ao22(input logic a, input logic b,
                                  input logic c, input logic d);
        return (a & b) | (c & d);
    endfunction

    // Next state of a two-input C-element
    function automatic logic c2_next(input logic x, input logic y,
                                     input logic z);
        return (x & y) | ((x | y) & z);
    endfunction

    function automatic logic rail_is_spacer(input rail_t r);
        return !(r.t | r.f);
    endfunction

    function automatic logic rail_is_legal(input rail_t r);
        return !(r.t & r.f);
    endfunction

endpackage

// File: rtl/c2_elem.sv
module c2_elem
    import eo_adder_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x,
    input  logic y,
    output logic z
);
    logic state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= 1'b0;
        else     state_q <= c2_next(x, y, state_q);
    end

    assign z = state_q;

endmodule

// File: rtl/eo_fa_cell.sv
module eo_fa_cell
    import eo_adder_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rail_t a,
    input  rail_t b,
    input  rail_t ci,
    output rail_t s,
    output rail_t co
);
    logic eq_g;    // operands equal (generate or kill)
    logic pr_g;    // operands differ (propagate)
    logic c_eq_t, c_eq_f, c_pr_t, c_pr_f;

    assign eq_g = ao22(a.f, b.f, a.t, b.t);
    assign pr_g = ao22(a.f, b.t, a.t, b.f);

    // carry path: input-incomplete, no waiting on carry-in when generating/killing
    assign co.t = ao22(pr_g, ci.t, a.t, b.t);
    assign co.f = ao22(pr_g, ci.f, a.f, b.f);

    c2_elem u_c_eq_t (.clk(clk), .rst(rst), .x(eq_g), .y(ci.t), .z(c_eq_t));
    c2_elem u_c_eq_f (.clk(clk), .rst(rst), .x(eq_g), .y(ci.f), .z(c_eq_f));
    c2_elem u_c_pr_t (.clk(clk), .rst(rst), .x(pr_g), .y(ci.t), .z(c_pr_t));
    c2_elem u_c_pr_f (.clk(clk), .rst(rst), .x(pr_g), .y(ci.f), .z(c_pr_f));

    assign s.t = c_eq_t | c_pr_f;
    assign s.f = c_eq_f | c_pr_t;

    AST_CELL_SUM_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(s.t && s.f)); // R10

    AST_CELL_CARRY_EXCL: assert property (@(posedge clk) disable iff (rst)
        (rail_is_legal(a) && rail_is_legal(b) && rail_is_legal(ci)) |-> !(co.t && co.f)); // R9

    AST_CELL_SUM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rail_is_spacer(a) && rail_is_spacer(b) && rail_is_spacer(ci)) |=> (!s.t && !s.f)); // R7

endmodule

// File: rtl/eo_ripple_chain.sv
module eo_ripple_chain
    import eo_adder_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDTH-1:0]  a_t,
    input  logic [WIDTH-1:0]  a_f,
    input  logic [WIDTH-1:0]  b_t,
    input  logic [WIDTH-1:0]  b_f,
    input  rail_t             cin,
    output logic [WIDTH-1:0]  sum_t,
    output logic [WIDTH-1:0]  sum_f,
    output rail_t             carry_raw
);
    localparam int unsigned NCARRY = WIDTH + 1;

    rail_t carry_w [NCARRY];

    assign carry_w[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        rail_t a_r, b_r, s_r;
        assign a_r = '{t: a_t[i], f: a_f[i]};
        assign b_r = '{t: b_t[i], f: b_f[i]};

        eo_fa_cell u_cell (
            .clk (clk),
            .rst (rst),
            .a   (a_r),
            .b   (b_r),
            .ci  (carry_w[i]),
            .s   (s_r),
            .co  (carry_w[i+1])
        );

        assign sum_t[i] = s_r.t;
        assign sum_f[i] = s_r.f;
    end

    assign carry_raw = carry_w[WIDTH];

endmodule

// File: rtl/carry_rendezvous.sv
module carry_rendezvous
    import eo_adder_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rail_t carry_in,
    input  logic  ack,
    output rail_t carry_out
);
    c2_elem u_sync_t (.clk(clk), .rst(rst), .x(carry_in.t), .y(ack), .z(carry_out.t));
    c2_elem u_sync_f (.clk(clk), .rst(rst), .x(carry_in.f), .y(ack), .z(carry_out.f));

    AST_SYNC_RISE_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        ($rose(carry_out.t) || $rose(carry_out.f)) |-> $past(ack)); // R4

    AST_SYNC_FALL_NEEDS_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
        ($fell(carry_out.t) || $fell(carry_out.f)) |-> !$past(ack)); // R6

    AST_SYNC_HOLD_WHILE_ACK: assert property (@(posedge clk) disable iff (rst)
        (ack && (carry_out.t || carry_out.f)) |=> $stable(carry_out)); // R5

    AST_SYNC_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({carry_out.t, carry_out.f})); // R9

endmodule

// File: rtl/eo_adder_stage.sv
module eo_adder_stage
    import eo_adder_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDTH-1:0]  a_t,
    input  logic [WIDTH-1:0]  a_f,
    input  logic [WIDTH-1:0]  b_t,
    input  logic [WIDTH-1:0]  b_f,
    input  logic              cin_t,
    input  logic              cin_f,
    input  logic              ack,
    output logic [WIDTH-1:0]  sum_t,
    output logic [WIDTH-1:0]  sum_f,
    output logic              cout_t,
    output logic              cout_f
);
    rail_t cin_r, carry_raw, carry_sync;

    assign cin_r = '{t: cin_t, f: cin_f};

    eo_ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .a_t       (a_t),
        .a_f       (a_f),
        .b_t       (b_t),
        .b_f       (b_f),
        .cin       (cin_r),
        .sum_t     (sum_t),
        .sum_f     (sum_f),
        .carry_raw (carry_raw)
    );

    carry_rendezvous u_sync (
        .clk       (clk),
        .rst       (rst),
        .carry_in  (carry_raw),
        .ack       (ack),
        .carry_out (carry_sync)
    );

    assign cout_t = carry_sync.t;
    assign cout_f = carry_sync.f;

    AST_COUT_WITHHELD: assert property (@(posedge clk) disable iff (rst)
        (!ack && !cout_t && !cout_f) |=> (!cout_t && !cout_f)); // R3

    AST_SUM_RAILS_EXCL: assert property (@(posedge clk) disable iff (rst)
        ((sum_t & sum_f) == '0)); // R10

endmodule

// File: tb/test_eo_adder_stage.sv
module test_eo_adder_stage;

    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
    logic cin_t = 1'b0, cin_f = 1'b0, ack = 1'b0;
    logic [W-1:0] sum_t, sum_f;
    logic cout_t, cout_f;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;   // 50 MHz

    eo_adder_stage #(.WIDTH(W)) i_eo_adder_stage (
        .clk(clk), .rst(rst),
        .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .cin_t(cin_t), .cin_f(cin_f), .ack(ack),
        .sum_t(sum_t), .sum_f(sum_f), .cout_t(cout_t), .cout_f(cout_f)
    );

    function automatic logic [W:0] ref_add(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic c);
        return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    endfunction

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic drive_valid(input logic [W-1:0] a, input logic [W-1:0] b,
                               input logic c);
        a_t = a; a_f = ~a; b_t = b; b_f = ~b; cin_t = c; cin_f = ~c;
    endtask

    task automatic drive_spacer();
        a_t = '0; a_f = '0; b_t = '0; b_f = '0; cin_t = 1'b0; cin_f = 1'b0;
    endtask

    task automatic txn(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input string tag);
        logic [W:0] r;
        r = ref_add(a, b, c);
        drive_valid(a, b, c);
        step();
        chk({"R2 sum_t ", tag}, {32'h0, sum_t}, {32'h0, r[W-1:0]});
        chk({"R2 sum_f ", tag}, {32'h0, sum_f}, {32'h0, ~r[W-1:0]});
        chk({"R10 sum rails ", tag}, {32'h0, sum_t & sum_f}, 64'h0);
        chk({"R3 carry withheld ", tag}, {62'h0, cout_t, cout_f}, 64'h0);
        ack = 1'b1;
        step();
        chk({"R4 carry valid ", tag}, {62'h0, cout_t, cout_f}, {62'h0, r[W], ~r[W]});
        drive_spacer();
        step();
        chk({"R7 sums spacer ", tag}, {sum_t, sum_f}, 64'h0);
        chk({"R5 carry held ", tag}, {62'h0, cout_t, cout_f}, {62'h0, r[W], ~r[W]});
        ack = 1'b0;
        step();
        chk({"R6 carry spacer ", tag}, {62'h0, cout_t, cout_f}, 64'h0);
        step();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 0);
        $finish;
    end

    initial begin : main
        process::self().srandom(32'd5150);
        step();
        step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 sums after reset", {sum_t, sum_f}, 64'h0);
        chk("R1 carry after reset", {62'h0, cout_t, cout_f}, 64'h0);

        // R12 completion with spacer carry does not produce a carry
        ack = 1'b1;
        step();
        chk("R12 carry stays spacer", {62'h0, cout_t, cout_f}, 64'h0);
        ack = 1'b0;
        step();

        // directed corners
        txn(32'h0, 32'h0, 1'b0, "zero");
        txn(32'hFFFF_FFFF, 32'h0, 1'b1, "R11 full ripple");
        txn(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "all ones");
        txn(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "alternating");
        txn(32'h8000_0000, 32'h8000_0000, 1'b0, "top generate");

        // R11 explicit result
        drive_valid(32'hFFFF_FFFF, 32'h0, 1'b1);
        step();
        chk("R11 ripple sum", {32'h0, sum_t}, 64'h0);
        ack = 1'b1;
        step();
        chk("R11 ripple carry", {62'h0, cout_t, cout_f}, {62'h0, 2'b10});
        drive_spacer();
        step();
        ack = 1'b0;
        step();
        step();

        // R8 early reset on bit 0 generate
        drive_valid(32'h1, 32'h1, 1'b0);
        step();
        chk("R8 setup bit1 true", {63'h0, sum_t[1]}, 64'h1);
        a_t = '0; a_f = '0; b_t = 32'h1; b_f = '0; cin_t = 1'b0; cin_f = 1'b1;
        step();
        chk("R8 bit1 cleared early", {62'h0, sum_t[1], sum_f[1]}, 64'h0);
        chk("R8 bit0 still held", {63'h0, sum_f[0]}, 64'h1);
        drive_spacer();
        step();
        chk("R8 bit0 cleared", {sum_t, sum_f}, 64'h0);
        step();

        // random transactions
        for (int k = 0; k < 60; k++) begin
            logic [W-1:0] ra, rb;
            logic rc;
            ra = $urandom();
            rb = $urandom();
            rc = 1'($urandom());
            txn(ra, rb, rc, "random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule